// File: doc/BRIEF.md
# Two-Road Sensor-Driven Traffic Light Controller

This block controls the lights at a crossing of two roads, A and B. Each road has a sensor that is high while traffic waits or flows on it. The block is a Moore state machine: the two light codes come only from the registered phase, never straight from the sensors. One road is green at a time.

The green road keeps its green for as long as its own sensor stays high. When the sensor drops, that road shows yellow for exactly one clock cycle. Green then passes to the other road, which follows the same rule. Because one clock cycle is one timing unit, the clock period sets the yellow time.

A parameter chooses how the phase register is built: a compact binary code or a one-hot vector. Both choices give the same behaviour at the ports. A synchronous, active-high reset starts the crossing with road A green.

Top module: `tlc_crossing`

## Requirements
- R1: A clock edge with `rst` high puts the block in the A-green phase, whatever the sensors show. After that edge `light_a` is green (2'b00) and `light_b` is red (2'b10).
- R2: In the A-green phase, an edge with `sense_a` high keeps `light_a` green and `light_b` red.
- R3: In the A-green phase, an edge with `sense_a` low makes `light_a` yellow (2'b01) while `light_b` stays red.
- R4: A-yellow lasts exactly one cycle. The next edge makes `light_a` red and `light_b` green, whatever the sensors show.
- R5: In the B-green phase, an edge with `sense_b` high keeps `light_b` green and `light_a` red.
- R6: In the B-green phase, an edge with `sense_b` low makes `light_b` yellow while `light_a` stays red.
- R7: B-yellow lasts exactly one cycle. The next edge makes `light_a` green and `light_b` red, whatever the sensors show.
- R8: At every cycle, at least one of `light_a` and `light_b` is red (2'b10). The code 2'b11 never appears.
- R9: The outputs change only at clock edges. Sensor changes between edges leave `light_a` and `light_b` unchanged.
- R10: With the parameter `ONE_HOT` set to 1, the phase register holds exactly one set bit, and the port behaviour matches R1 to R9 cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is one light-timing unit |
| rst | input | 1 | Synchronous reset, active high |
| sense_a | input | 1 | High while road A has traffic |
| sense_b | input | 1 | High while road B has traffic |
| light_a | output | 2 | Road A light: 00 green, 01 yellow, 10 red |
| light_b | output | 2 | Road B light: 00 green, 01 yellow, 10 red |

## Verification
The bench builds two copies of the block side by side. One has `ONE_HOT` = 0, the binary phase register, and the other has `ONE_HOT` = 1. Both get the same sensor and reset stimulus, and both are compared against one reference model. This covers both register variants, including the one-hot check inside the register. Long sensor-high runs reach the hold cases, and sensor toggles between edges exercise the Moore property. Resets asserted in the middle of each phase, with the sensors in every combination, exercise the reset override.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

   localparam int NUM_PH  = 4;
   localparam int PH_W    = $clog2(NUM_PH);
   localparam int LIGHT_W = 2;

   typedef enum logic [PH_W-1:0] {
      PH_AG = 2'd0,
      PH_AY = 2'd1,
      PH_BG = 2'd2,
      PH_BY = 2'd3
   } phase_t;

   typedef enum logic [LIGHT_W-1:0] {
      LT_GREEN  = 2'b00,
      LT_YELLOW = 2'b01,
      LT_RED    = 2'b10
   } light_t;

endpackage

// File: rtl/tlc_next_state.sv
module tlc_next_state
   import tlc_pkg::*;
(
   input  phase_t cur,
   input  logic   sense_a,
   input  logic   sense_b,
   output phase_t nxt
);

   always_comb begin
      nxt = cur;
      unique case (cur)
         PH_AG: nxt = sense_a ? PH_AG : PH_AY;
         PH_AY: nxt = PH_BG;
         PH_BG: nxt = sense_b ? PH_BG : PH_BY;
         PH_BY: nxt = PH_AG;
         default: nxt = PH_AG;
      endcase
   end

endmodule

// File: rtl/tlc_state_reg.sv
module tlc_state_reg
   import tlc_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
)(
   input  logic   clk,
   input  logic   rst,
   input  phase_t nxt,
   output phase_t cur
);

   generate
      if (ONE_HOT) begin : g_onehot
         localparam logic [NUM_PH-1:0] ONE = {{(NUM_PH-1){1'b0}}, 1'b1};
         logic [NUM_PH-1:0] hot_q;

         always_ff @(posedge clk) begin
            if (rst) hot_q <= ONE << PH_AG;
            else     hot_q <= ONE << nxt;
         end

         always_comb begin
            cur = PH_AG;
            for (int i = 0; i < NUM_PH; i++) begin
               if (hot_q[i]) cur = phase_t'(PH_W'(i));
            end
         end

         AST_ONEHOT_PHASE: assert property (@(posedge clk) disable iff (rst)
            $past(rst) || $onehot0(hot_q) && (hot_q != '0)) else $error("one-hot phase broken"); // R10
      end else begin : g_binary
         phase_t ph_q;

         always_ff @(posedge clk) begin
            if (rst) ph_q <= PH_AG;
            else     ph_q <= nxt;
         end

         assign cur = ph_q;
      end
   endgenerate

endmodule

// File: rtl/tlc_light_decode.sv
module tlc_light_decode
   import tlc_pkg::*;
(
   input  phase_t                cur,
   output logic [LIGHT_W-1:0]    light_a,
   output logic [LIGHT_W-1:0]    light_b
);

   always_comb begin
      light_a = LT_RED;
      light_b = LT_RED;
      unique case (cur)
         PH_AG: light_a = LT_GREEN;
         PH_AY: light_a = LT_YELLOW;
         PH_BG: light_b = LT_GREEN;
         PH_BY: light_b = LT_YELLOW;
         default: begin
            light_a = LT_RED;
            light_b = LT_RED;
         end
      endcase
   end

endmodule

// File: rtl/tlc_crossing.sv
module tlc_crossing
   import tlc_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
)(
   input  logic               clk,
   input  logic               rst,
   input  logic               sense_a,
   input  logic               sense_b,
   output logic [1:0]         light_a,
   output logic [1:0]         light_b
);

   phase_t ph_cur;
   phase_t ph_nxt;
   logic   rst_q;

   tlc_next_state u_next (
      .cur     (ph_cur),
      .sense_a (sense_a),
      .sense_b (sense_b),
      .nxt     (ph_nxt)
   );

   tlc_state_reg #(.ONE_HOT(ONE_HOT)) u_reg (
      .clk (clk),
      .rst (rst),
      .nxt (ph_nxt),
      .cur (ph_cur)
   );

   tlc_light_decode u_dec (
      .cur     (ph_cur),
      .light_a (light_a),
      .light_b (light_b)
   );

   always_ff @(posedge clk) rst_q <= rst;

   AST_RESET_A_GREEN: assert property (@(posedge clk) disable iff (rst)
      rst_q |-> (light_a == LT_GREEN && light_b == LT_RED)) else $error("reset state"); // R1
   AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
      (light_a == LT_GREEN && sense_a) |=> (light_a == LT_GREEN && light_b == LT_RED)) else $error("A hold"); // R2
   AST_A_TO_YELLOW: assert property (@(posedge clk) disable iff (rst)
      (light_a == LT_GREEN && !sense_a) |=> (light_a == LT_YELLOW && light_b == LT_RED)) else $error("A yellow"); // R3
   AST_A_YELLOW_ONE: assert property (@(posedge clk) disable iff (rst)
      (light_a == LT_YELLOW) |=> (light_a == LT_RED && light_b == LT_GREEN)) else $error("A yellow len"); // R4
   AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
      (light_b == LT_GREEN && sense_b) |=> (light_b == LT_GREEN && light_a == LT_RED)) else $error("B hold"); // R5
   AST_B_TO_YELLOW: assert property (@(posedge clk) disable iff (rst)
      (light_b == LT_GREEN && !sense_b) |=> (light_b == LT_YELLOW && light_a == LT_RED)) else $error("B yellow"); // R6
   AST_B_YELLOW_ONE: assert property (@(posedge clk) disable iff (rst)
      (light_b == LT_YELLOW) |=> (light_a == LT_GREEN && light_b == LT_RED)) else $error("B yellow len"); // R7
   AST_ONE_ROAD_MOVING: assert property (@(posedge clk) disable iff (rst)
      (light_a == LT_RED || light_b == LT_RED) && light_a != 2'b11 && light_b != 2'b11) else $error("conflict"); // R8

endmodule

// File: tb/tlc_crossing_tb_top.sv
`timescale 1ns/1ps
module tlc_crossing_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sense_a = 1'b0;
   logic       sense_b = 1'b0;
   logic [1:0] light_a, light_b;
   logic [1:0] oh_light_a, oh_light_b;

   int n_tests = 0;
   int n_fail  = 0;
   int model   = 0;     // 0 A green, 1 A yellow, 2 B green, 3 B yellow
   bit done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   tlc_crossing #(.ONE_HOT(1'b0)) dut_i (
      .clk(clk), .rst(rst), .sense_a(sense_a), .sense_b(sense_b),
      .light_a(light_a), .light_b(light_b));

   tlc_crossing #(.ONE_HOT(1'b1)) dut_oh (
      .clk(clk), .rst(rst), .sense_a(sense_a), .sense_b(sense_b),
      .light_a(oh_light_a), .light_b(oh_light_b));

   function automatic int next_model(int ph, bit r, bit sa, bit sb);
      if (r) return 0;
      case (ph)
         0: return sa ? 0 : 1;
         1: return 2;
         2: return sb ? 2 : 3;
         default: return 0;
      endcase
   endfunction

   function automatic logic [1:0] exp_a(int ph);
      return (ph == 0) ? 2'b00 : (ph == 1) ? 2'b01 : 2'b10;
   endfunction

   function automatic logic [1:0] exp_b(int ph);
      return (ph == 2) ? 2'b00 : (ph == 3) ? 2'b01 : 2'b10;
   endfunction

   function automatic string tag_of(int ph, bit r, bit sa, bit sb);
      if (r) return "R1";
      case (ph)
         0: return sa ? "R2" : "R3";
         1: return "R4";
         2: return sb ? "R5" : "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check_lights(string tag);
      n_tests++;
      if (light_a !== exp_a(model) || light_b !== exp_b(model)) begin
         n_fail++;
         $display("FAIL %s binary: a=%b b=%b expected a=%b b=%b", tag,
                  light_a, light_b, exp_a(model), exp_b(model));
      end
      n_tests++;
      if (oh_light_a !== exp_a(model) || oh_light_b !== exp_b(model)) begin
         n_fail++;
         $display("FAIL %s/R10 one-hot: a=%b b=%b expected a=%b b=%b", tag,
                  oh_light_a, oh_light_b, exp_a(model), exp_b(model));
      end
      n_tests++;
      if (light_a !== 2'b10 && light_b !== 2'b10) begin
         n_fail++;
         $display("FAIL R8: a=%b b=%b expected one red (10)", light_a, light_b);
      end
   endtask

   // Apply one cycle: inputs set after the negedge, model stepped at posedge,
   // outputs checked at the following negedge.
   task automatic step(bit r, bit sa, bit sb, bit wiggle);
      string tg;
      tg = tag_of(model, r, sa, sb);
      rst = r; sense_a = sa; sense_b = sb;
      @(posedge clk);
      model = next_model(model, r, sa, sb);
      @(negedge clk);
      check_lights(tg);
      if (wiggle) begin
         logic [1:0] ha, hb;
         ha = light_a; hb = light_b;
         sense_a = ~sense_a; #2; sense_b = ~sense_b; #2; sense_a = ~sense_a; #2;
         n_tests++;
         if (light_a !== ha || light_b !== hb) begin
            n_fail++;
            $display("FAIL R9: a=%b b=%b expected a=%b b=%b", light_a, light_b, ha, hb);
         end
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      step(1, 1, 1, 0);            // R1 with sensors high
      step(1, 0, 0, 0);
      // Directed: hold A, hand over, hold B, hand back
      step(0, 1, 0, 1);            // R2
      step(0, 1, 1, 1);            // R2
      step(0, 0, 1, 1);            // R3
      step(0, 1, 1, 1);            // R4 sensors ignored
      step(0, 0, 1, 1);            // R5
      step(0, 1, 1, 0);            // R5
      step(0, 1, 0, 1);            // R6
      step(0, 0, 0, 1);            // R7 sensors ignored
      step(0, 0, 0, 0);            // R3 from A green
      step(0, 0, 0, 0);            // R4 with sensors low
      // Reset in each phase
      for (int p = 0; p < 4; p++) begin
         while (model != p) step(0, 1'b0, 1'b0, 0);
         step(1, 1'b1, 1'b1, 0);   // R1 overrides sensors
      end
      // Constrained random: sensors biased high for long holds, rare resets
      for (int i = 0; i < 3000; i++) begin
         bit r, sa, sb;
         r  = ($urandom % 64) == 0;
         sa = ($urandom % 4) != 0;
         sb = ($urandom % 4) != 0;
         step(r, sa, sb, ($urandom % 8) == 0);
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule